// File: doc/BRIEF.md
# PWM Generator with Period-Match Timer

This block produces a pulse-width-modulated output from an 8-bit up-counter that wraps at a programmable period. A prescaler slows the counter to one step every 4, 16 or 64 input clocks. When the counter reaches the period value, three things happen at the end of that step. The counter returns to zero, a sticky match flag is raised, and a new PWM cycle begins with the output driven high.

The duty value is 10 bits wide. Eight coarse bits come from one input and two fine bits from another. The block compares the duty value against the counter extended by a 2-bit sub-step phase taken from the prescaler. This gives the output a resolution of a quarter counter step. The duty value is captured only at the start of each PWM cycle, so software can rewrite it at any time without producing a short or stretched pulse.

The output is active only when the 4-bit mode selector holds a PWM code. The timer, and with it the flag and the PWM waveform, can be frozen with a stop input.

Top module: `pwm_period_timer`

## Requirements
- R1: `prescaleCode` sets the length of a counter step in input clocks. The encodings are 2'b00 = 4 clocks, 2'b01 = 16 clocks, and 2'b10 or 2'b11 = 64 clocks.
- R2: While running, the counter counts 0 up to `periodVal` and then wraps to 0. One PWM cycle therefore lasts (`periodVal`+1) x step clocks.
- R3: `matchFlag` goes high one clock after the last clock of the step in which the counter equals `periodVal`. It stays high until `flagClear` is sampled high. When a new match and a clear fall in the same clock, the match wins.
- R4: While `timerOff` is 1 the counter and the prescaler hold their values. During that time `matchFlag` is not set and `pwmOut` does not change.
- R5: `pwmOut` is driven only when `modeSel[3:2]` == 2'b11. Any other mode code holds it at 0.
- R6: In PWM mode, `pwmOut` rises in the same clock that `matchFlag` is set by a wrap.
- R7: The duty value D is {`dutyHigh`, `dutyLow`}, with `dutyLow` as the two least significant bits. The high time of each PWM cycle is D x step/4 input clocks.
- R8: D is captured at each wrap. A change of `dutyHigh` or `dutyLow` during a PWM cycle does not alter the pulse already in progress.
- R9: If D exceeds {`periodVal`, 2'b11}, `pwmOut` stays high for the whole cycle, across successive wraps.
- R10: If D is 0, `pwmOut` stays low.
- R11: After reset, `pwmOut` and `matchFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; every counter step is a multiple of it |
| rstN | input | 1 | Asynchronous active-low reset |
| timerOff | input | 1 | 1 stops the counter and prescaler, 0 runs them |
| prescaleCode | input | 2 | Step length select (4, 16, 64 clocks) |
| periodVal | input | 8 | Last counter value before wrap |
| dutyHigh | input | 8 | Upper eight duty bits |
| dutyLow | input | 2 | Two fine duty bits |
| modeSel | input | 4 | Operating mode; 2'b11 in bits 3:2 selects PWM |
| flagClear | input | 1 | Clears the match flag |
| pwmOut | output | 1 | PWM waveform |
| matchFlag | output | 1 | Sticky period-match flag |

## Verification
The hardest condition to reach from the ports is the duty-capture boundary. The duty inputs must change while a pulse is already in flight, and the bench must show that only the next cycle sees the new value. The bench waits for a rising edge of `pwmOut`, rewrites the duty inputs during the high phase, and measures that pulse against the old value. The saturated cases (D above the extended period, and D of zero) produce no edges at all. They are checked by holding the configuration over several full cycles and sampling the level on every clock. For the per-cycle measurements, the bench skips the first cycle after a reconfiguration, so that a step already part-way through its prescaler count does not distort the result.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int TMR_W  = 8;
  localparam int FINE_W = 2;
  localparam int PRE_W  = 6;
  localparam int DUTY_W = TMR_W + FINE_W;

  typedef struct packed {
    logic              advance;
    logic [FINE_W-1:0] fine;
  } stepStrobe_t;

  typedef struct packed {
    logic wrap;
    logic dutyHit;
  } dpStatus_t;
endpackage

// File: rtl/pwmt_ctl.sv
module pwmt_ctl
  import pwmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        timerOff,
  input  logic [1:0]  prescaleCode,
  input  logic        pwmEnable,
  input  logic        flagClear,
  input  dpStatus_t   dpStat,
  output stepStrobe_t strobe,
  output logic        pwmOut,
  output logic        matchFlag
);
  logic [PRE_W-1:0] subCnt;
  logic [PRE_W-1:0] lastIdx;
  logic             run;
  logic             pwmLevel;

  assign run = !timerOff;

  always_comb begin
    unique case (prescaleCode)
      2'b00: begin
        lastIdx     = PRE_W'(3);
        strobe.fine = subCnt[1:0];
      end
      2'b01: begin
        lastIdx     = PRE_W'(15);
        strobe.fine = subCnt[3:2];
      end
      default: begin
        lastIdx     = PRE_W'(63);
        strobe.fine = subCnt[5:4];
      end
    endcase
    strobe.advance = run && (subCnt >= lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (run) begin
      subCnt <= strobe.advance ? '0 : subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
    end else if (dpStat.wrap) begin
      matchFlag <= 1'b1;
    end else if (flagClear) begin
      matchFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmLevel <= 1'b0;
    end else if (!pwmEnable) begin
      pwmLevel <= 1'b0;
    end else if (dpStat.wrap) begin
      pwmLevel <= 1'b1;
    end else if (dpStat.dutyHit) begin
      pwmLevel <= 1'b0;
    end
  end

  assign pwmOut = pwmEnable && pwmLevel && !dpStat.dutyHit;
endmodule

// File: rtl/pwmt_dp.sv
module pwmt_dp
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobe_t       strobe,
  input  logic [TMR_W-1:0]  periodVal,
  input  logic [TMR_W-1:0]  dutyHigh,
  input  logic [FINE_W-1:0] dutyLow,
  output dpStatus_t         dpStat
);
  logic [TMR_W-1:0]  timerCnt;
  logic [DUTY_W-1:0] dutyHeld;

  always_comb begin
    dpStat.wrap    = strobe.advance && (timerCnt == periodVal);
    dpStat.dutyHit = ({timerCnt, strobe.fine} == dutyHeld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
      dutyHeld <= '0;
    end else if (dpStat.wrap) begin
      timerCnt <= '0;
      dutyHeld <= {dutyHigh, dutyLow};
    end else if (strobe.advance) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerOff,
  input  logic [1:0]        prescaleCode,
  input  logic [TMR_W-1:0]  periodVal,
  input  logic [TMR_W-1:0]  dutyHigh,
  input  logic [FINE_W-1:0] dutyLow,
  input  logic [3:0]        modeSel,
  input  logic              flagClear,
  output logic              pwmOut,
  output logic              matchFlag
);
  stepStrobe_t strobe;
  dpStatus_t   dpStat;
  logic        pwmEnable;

  assign pwmEnable = (modeSel[3:2] == 2'b11);

  pwmt_ctl u_ctl (
    .clk(clk), .rstN(rstN), .timerOff(timerOff), .prescaleCode(prescaleCode),
    .pwmEnable(pwmEnable), .flagClear(flagClear), .dpStat(dpStat),
    .strobe(strobe), .pwmOut(pwmOut), .matchFlag(matchFlag)
  );

  pwmt_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodVal(periodVal),
    .dutyHigh(dutyHigh), .dutyLow(dutyLow), .dpStat(dpStat)
  );
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timerOff,
  input logic [3:0] modeSel,
  input logic       flagClear,
  input logic       pwmOut,
  input logic       matchFlag
);
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[3:2] != 2'b11) |-> !pwmOut); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClear) |=> matchFlag); // R3

  AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> !$past(timerOff)); // R4

  AST_RISE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> matchFlag); // R6

  AST_FROZEN_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    (timerOff && $past(timerOff) && $stable(modeSel)) |-> $stable(pwmOut)); // R4
endmodule

bind pwm_period_timer pwmt_chk u_chk (
  .clk(clk), .rstN(rstN), .timerOff(timerOff), .modeSel(modeSel),
  .flagClear(flagClear), .pwmOut(pwmOut), .matchFlag(matchFlag)
);

// File: tb/test_pwm_period_timer.sv
module test_pwm_period_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timerOff = 1'b0;
  logic [1:0] prescaleCode = 2'b00;
  logic [7:0] periodVal = 8'hFF;
  logic [7:0] dutyHigh = 8'd0;
  logic [1:0] dutyLow = 2'd0;
  logic [3:0] modeSel = 4'b0000;
  logic       flagClear = 1'b0;
  logic       pwmOut;
  logic       matchFlag;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int    expHigh;
    int    expPeriod;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  pwm_period_timer i_pwm_period_timer (
    .clk(clk), .rstN(rstN), .timerOff(timerOff), .prescaleCode(prescaleCode),
    .periodVal(periodVal), .dutyHigh(dutyHigh), .dutyLow(dutyLow),
    .modeSel(modeSel), .flagClear(flagClear), .pwmOut(pwmOut), .matchFlag(matchFlag)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic waitRise();
    @(negedge clk);
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
  endtask

  // monitor: measures the second full PWM cycle after an item is queued
  initial begin
    forever begin
      int hi;
      int per;
      wait (expQ.size() > 0);
      waitRise();
      waitRise();
      hi = 0;
      while (pwmOut) begin hi++; @(negedge clk); end
      per = hi;
      while (!pwmOut) begin per++; @(negedge clk); end
      chk({expQ[0].tag, " R7 high time"}, hi, expQ[0].expHigh);
      chk({expQ[0].tag, " R2 period"}, per, expQ[0].expPeriod);
      void'(expQ.pop_front());
    end
  end

  task automatic runCase(string tag, logic [1:0] code, int stepLen,
                         logic [7:0] per, logic [7:0] hi, logic [1:0] lo);
    expItem_t it;
    @(negedge clk);
    prescaleCode = code;
    periodVal    = per;
    dutyHigh     = hi;
    dutyLow      = lo;
    modeSel      = 4'b1100;
    it.expHigh   = (int'(hi) * 4 + int'(lo)) * stepLen / 4;
    it.expPeriod = (int'(per) + 1) * stepLen;
    it.tag       = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic holdLevel(string req, int clocks, logic level);
    int bad = 0;
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      if (pwmOut != level) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 pwmOut after reset", pwmOut, 0);
    chk("R11 matchFlag after reset", matchFlag, 0);
    rstN = 1'b1;

    // R1, R2, R7 across all prescale codes
    runCase("R1 code00", 2'b00, 4, 8'd9, 8'd3, 2'd3);
    runCase("R1 code01", 2'b01, 16, 8'd4, 8'd1, 2'd2);
    runCase("R1 code10", 2'b10, 64, 8'd2, 8'd2, 2'd1);
    runCase("R1 code11", 2'b11, 64, 8'd3, 8'd0, 2'd3);

    // R8: rewrite duty during a pulse; in-flight pulse keeps old width
    runCase("R8 setup", 2'b00, 4, 8'd9, 8'd3, 2'd3);
    begin
      int hi = 0;
      waitRise();
      dutyHigh = 8'd8;
      dutyLow  = 2'd0;
      while (pwmOut) begin hi++; @(negedge clk); end
      chk("R8 in-flight pulse width", hi, 15);
      waitRise();
      hi = 0;
      while (pwmOut) begin hi++; @(negedge clk); end
      chk("R8 next pulse uses new duty", hi, 32);
    end

    // R3: flag spacing with clear held high (set wins, one-clock flag)
    begin
      int gap = 0;
      dutyHigh  = 8'd3;
      flagClear = 1'b1;
      @(negedge clk);
      while (!matchFlag) @(negedge clk);
      @(negedge clk);
      chk("R3 flag drops next clock under clear", matchFlag, 0);
      gap = 1;
      while (!matchFlag) begin gap++; @(negedge clk); end
      chk("R3 match spacing", gap, 40);
      flagClear = 1'b0;
      repeat (100) @(negedge clk);
      chk("R3 flag sticky", matchFlag, 1);
    end

    // R4: stop the timer
    begin
      int changes = 0;
      logic held;
      timerOff = 1'b1;
      @(negedge clk);
      flagClear = 1'b1;
      @(negedge clk);
      flagClear = 1'b0;
      held = pwmOut;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (pwmOut != held || matchFlag) changes++;
      end
      chk("R4 frozen while off", changes, 0);
      timerOff = 1'b0;
      repeat (60) @(negedge clk);
      chk("R4 resumes after off", matchFlag, 1);
    end

    // R9: duty beyond extended period
    dutyHigh = 8'd10;
    dutyLow  = 2'd0;
    repeat (120) @(negedge clk);
    holdLevel("R9 stays high", 120, 1'b1);

    // R10: zero duty
    dutyHigh = 8'd0;
    repeat (120) @(negedge clk);
    holdLevel("R10 stays low", 120, 1'b0);

    // R5: non-PWM mode code with a valid duty
    dutyHigh = 8'd3;
    dutyLow  = 2'd3;
    modeSel  = 4'b1000;
    holdLevel("R5 mode 1000 low", 120, 1'b0);
    modeSel  = 4'b0111;
    holdLevel("R5 mode 0111 low", 120, 1'b0);
    modeSel  = 4'b1101;
    repeat (100) @(negedge clk);
    begin
      int hi = 0;
      waitRise();
      while (pwmOut) begin hi++; @(negedge clk); end
      chk("R5 mode 1101 drives PWM", hi, 15);
    end

    finishRun();
  end
endmodule